// File: doc/BRIEF.md
# Audio Frame Sequencer

The block generates the slow control strobes that pace the length, sweep and envelope units of a four-channel sound unit. It does not count time itself: it watches a free-running 16-bit divider value supplied from outside and takes one step each time bit 12 of that value goes from 1 to 0. It compares the value seen in consecutive clock cycles to detect this.

The block cycles through eight steps. Each step pulses some subset of three strobes, and then the step pointer moves on. The block also outputs the current step and a lookahead flag. The flag tells the channel logic whether the step about to be processed will clock the length counters. Channel logic needs this when a length-enable or trigger write lands between two steps.

A level input says whether the sound unit is on. While the unit is off, all strobes are held low and the pointer is frozen. A 0-to-1 change of that input puts the pointer back to step 0.

Top module: `snd_frame_seq`

## Requirements
- R1: The pointer advances only when div_i[12] is 1 in one clock cycle and 0 in the next. Changes of any other divider bit, and 0-to-1 changes of bit 12, have no effect on the strobes or the pointer.
- R2: In the first clock cycle after reset is released, no step is taken, even if div_i[12] reads 0 while it read 1 during reset.
- R3: The strobes depend on the step being processed:
  - Steps 0, 2, 4 and 6 raise len_stb_o.
  - Steps 2 and 6 also raise swp_stb_o.
  - Step 7 raises env_stb_o.
  - Steps 1, 3 and 5 raise nothing.
- R4: Strobes are high only during the cycle in which the falling edge is seen, as a combinational function of the inputs of that cycle. They are low in every other cycle.
- R5: step_o gives the next step to be processed. It increments by one on the clock edge that ends a processed step and wraps from 7 to 0.
- R6: next_len_o is 1 exactly when step_o is even, meaning the next processed step will clock length.
- R7: While unit_en_i is 0, all strobes stay 0 and step_o holds its value, even when falling edges arrive.
- R8: In a cycle where unit_en_i is 1 after being 0 in the previous cycle, no strobe is raised and step_o becomes 0 at the following edge.
- R9: After reset, step_o is 0, next_len_o is 1 and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_i | input | 16 | Free-running divider value |
| unit_en_i | input | 1 | Sound unit on (1) or off (0) |
| len_stb_o | output | 1 | Length clock strobe |
| swp_stb_o | output | 1 | Sweep clock strobe |
| env_stb_o | output | 1 | Envelope clock strobe |
| step_o | output | 3 | Next step to be processed |
| next_len_o | output | 1 | Next step clocks length |

## Verification
The main function is tried with several divider patterns:
- A clean sequence of bit-12 falls run through a full wrap. This checks the per-step strobe table and the lookahead.
- Toggles of the neighbouring bits 11 and 13, and a rising bit 12. These separate a correct edge detector from one that reacts to levels or to the wrong bit.
- A fall that arrives straight out of reset. This tells whether the previous-value register is trusted before it holds a real sample.
- Falls while the unit is off, and a fall in the turn-on cycle. These show whether the off state gates both the strobes and the pointer, and whether a power-on restart wins over a coincident step.

// File: rtl/snd_fs_pkg.sv
// Shared types and step table for the audio frame sequencer.
// Assumes a power-of-two cycle of steps so the pointer wraps naturally.
package snd_fs_pkg;

    localparam int STEP_W  = 3;
    localparam int N_STEPS = 1 << STEP_W;

    typedef logic [STEP_W-1:0] step_t;

    typedef struct packed {
        logic len;
        logic swp;
        logic env;
    } fs_strobe_t;

    // Strobe set raised by a given step when it is processed.
    function automatic fs_strobe_t step_class(input step_t s);
        fs_strobe_t c;
        c.len = (s[0] == 1'b0);
        c.swp = (s == step_t'(2)) || (s == step_t'(6));
        c.env = (s == step_t'(N_STEPS - 1));
        return c;
    endfunction

endpackage

// File: rtl/snd_fs_tap_edge.sv
// Falling-edge detector on one bit of a free-running divider.
// Assumes the divider changes at most once per clock cycle. The first
// cycle after reset never reports an edge, because no real previous
// sample exists yet.
module snd_fs_tap_edge #(
    parameter int DIV_W = 16,
    parameter int TAP   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             fall_o
);

    logic prev_q;
    logic valid_q;

    // Keep last sample of the tap bit; it is only trusted once valid_q is set.
    always_ff @(posedge clk) begin
        prev_q <= div_i[TAP];
    end

    // Mark the stored sample as valid after one cycle out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= 1'b1;
    end

    // Report a 1-to-0 transition between the stored and the current sample.
    always_comb begin
        fall_o = valid_q && prev_q && !div_i[TAP];
    end

endmodule

// File: rtl/snd_fs_step_ptr.sv
// Step pointer of the frame sequencer.
// Assumes clr_i and adv_i are never both needed: clear wins.
module snd_fs_step_ptr
    import snd_fs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv_i,
    input  logic  clr_i,
    output step_t step_o
);

    step_t step_q;

    // Clear to step 0, or move on one step with natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) step_q <= '0;
        else if (adv_i)      step_q <= step_q + step_t'(1);
    end

    assign step_o = step_q;

endmodule

// File: rtl/snd_fs_decode.sv
// Turns the current step into strobes and the length lookahead.
// Assumes fire_i is high for exactly the cycle that processes the step.
module snd_fs_decode
    import snd_fs_pkg::*;
(
    input  step_t step_i,
    input  logic  fire_i,
    output logic  len_o,
    output logic  swp_o,
    output logic  env_o,
    output logic  next_len_o
);

    fs_strobe_t cls;

    // Look up the step class and gate it with the fire pulse.
    always_comb begin
        cls        = step_class(step_i);
        len_o      = fire_i && cls.len;
        swp_o      = fire_i && cls.swp;
        env_o      = fire_i && cls.env;
        next_len_o = cls.len;
    end

endmodule

// File: rtl/snd_frame_seq.sv
// Audio frame sequencer top.
// Steps once per falling edge of a chosen divider bit while the unit is on.
// A turn-on of the unit restarts at step 0 and suppresses any coincident step.
// Assumes unit_en_i is synchronous to clk.
module snd_frame_seq
    import snd_fs_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int TAP   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             unit_en_i,
    output logic             len_stb_o,
    output logic             swp_stb_o,
    output logic             env_stb_o,
    output logic [STEP_W-1:0] step_o,
    output logic             next_len_o
);

    logic  fall;
    logic  en_prev_q;
    logic  turn_on;
    logic  fire;
    step_t step;

    snd_fs_tap_edge #(.DIV_W(DIV_W), .TAP(TAP)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (div_i),
        .fall_o (fall)
    );

    // Remember the enable level; reset counts as already on.
    always_ff @(posedge clk) begin
        if (!rst_n) en_prev_q <= 1'b1;
        else        en_prev_q <= unit_en_i;
    end

    // Decide whether this cycle restarts or processes a step.
    always_comb begin
        turn_on = unit_en_i && !en_prev_q;
        fire    = fall && unit_en_i && !turn_on;
    end

    snd_fs_step_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (fire),
        .clr_i  (turn_on),
        .step_o (step)
    );

    snd_fs_decode u_dec (
        .step_i     (step),
        .fire_i     (fire),
        .len_o      (len_stb_o),
        .swp_o      (swp_stb_o),
        .env_o      (env_stb_o),
        .next_len_o (next_len_o)
    );

    assign step_o = step;

endmodule

// File: rtl/snd_frame_seq_chk.sv
// Checker for the audio frame sequencer, bound to the top module.
module snd_frame_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        unit_en_i,
    input logic        len_stb_o,
    input logic        swp_stb_o,
    input logic        env_stb_o,
    input logic [2:0]  step_o,
    input logic        next_len_o
);

    a_r3_len_even: assert property (@(posedge clk) disable iff (!rst_n)
        len_stb_o |-> (step_o[0] == 1'b0));

    a_r3_sweep_with_len: assert property (@(posedge clk) disable iff (!rst_n)
        swp_stb_o |-> (len_stb_o && (step_o == 3'd2 || step_o == 3'd6)));

    a_r3_env_last: assert property (@(posedge clk) disable iff (!rst_n)
        env_stb_o |-> (step_o == 3'd7 && !len_stb_o));

    a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (len_stb_o || env_stb_o) |=> (step_o == $past(step_o) + 3'd1));

    a_r6_lookahead: assert property (@(posedge clk) disable iff (!rst_n)
        next_len_o == !step_o[0]);

    a_r7_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en_i |-> !(len_stb_o || swp_stb_o || env_stb_o));

    a_r7_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en_i |=> (step_o == $past(step_o)));

    a_r8_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_en_i && !$past(unit_en_i)) |=> (step_o == 3'd0));

endmodule

bind snd_frame_seq snd_frame_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .unit_en_i  (unit_en_i),
    .len_stb_o  (len_stb_o),
    .swp_stb_o  (swp_stb_o),
    .env_stb_o  (env_stb_o),
    .step_o     (step_o),
    .next_len_o (next_len_o)
);

// File: tb/snd_frame_seq_tb.sv
module snd_frame_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] div = 16'h1000;
    logic        unit_en = 1'b1;
    logic        len_stb, swp_stb, env_stb, next_len;
    logic [2:0]  step;

    int n_run = 0;
    int n_fail = 0;
    int exp_step = 0;

    always #10 clk = ~clk;

    snd_frame_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_i      (div),
        .unit_en_i  (unit_en),
        .len_stb_o  (len_stb),
        .swp_stb_o  (swp_stb),
        .env_stb_o  (env_stb),
        .step_o     (step),
        .next_len_o (next_len)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling clock edge, then settle before the rising edge.
    task automatic cyc(input logic [15:0] d, input logic en);
        @(negedge clk);
        div = d;
        unit_en = en;
        #5;
    endtask

    function automatic int strobes_of(input int s);
        int len = (s % 2 == 0) ? 1 : 0;
        int swp = (s == 2 || s == 6) ? 1 : 0;
        int env = (s == 7) ? 1 : 0;
        return len * 4 + swp * 2 + env;
    endfunction

    function automatic int strobes_now();
        return int'(len_stb) * 4 + int'(swp_stb) * 2 + int'(env_stb);
    endfunction

    // One clean fall of bit 12 with the unit on; checks table, lookahead, advance.
    task automatic one_fall();
        cyc(16'h1000, 1'b1);
        chk("R6 lookahead", int'(next_len), (exp_step % 2 == 0) ? 1 : 0);
        chk("R1 rise ignored", strobes_now(), 0);
        cyc(16'h0000, 1'b1);
        chk("R3 strobes", strobes_now(), strobes_of(exp_step));
        exp_step = (exp_step + 1) % 8;
        cyc(16'h0000, 1'b1);
        chk("R4 single pulse", strobes_now(), 0);
        chk("R5 step advance", int'(step), exp_step);
    endtask

    task automatic t_reset();
        repeat (3) cyc(16'h1000, 1'b1);
        chk("R9 reset step", int'(step), 0);
        chk("R9 reset lookahead", int'(next_len), 1);
        chk("R9 reset strobes", strobes_now(), 0);
    endtask

    task automatic t_first_cycle();
        @(negedge clk);
        rst_n = 1'b1;
        div = 16'h0000;
        #5;
        chk("R2 no edge after reset", strobes_now(), 0);
        cyc(16'h0000, 1'b1);
        chk("R2 step held", int'(step), 0);
        exp_step = 0;
    endtask

    task automatic t_full_cycle();
        for (int i = 0; i < 9; i++) one_fall();
        chk("R5 wrap", int'(step), 1);
    endtask

    task automatic t_other_bits();
        cyc(16'h0800, 1'b1);
        cyc(16'h0000, 1'b1);
        chk("R1 bit 11 fall ignored", strobes_now(), 0);
        cyc(16'h2000, 1'b1);
        cyc(16'h0000, 1'b1);
        chk("R1 bit 13 fall ignored", strobes_now(), 0);
        cyc(16'h1FFF, 1'b1);
        chk("R1 bit 12 rise ignored", strobes_now(), 0);
        cyc(16'h1000, 1'b1);
        chk("R1 bit 12 high ignored", strobes_now(), 0);
        cyc(16'h1000, 1'b1);
        chk("R1 step unchanged", int'(step), exp_step);
    endtask

    task automatic t_off();
        while (exp_step != 3) one_fall();
        cyc(16'h1000, 1'b0);
        for (int i = 0; i < 3; i++) begin
            cyc(16'h0000, 1'b0);
            chk("R7 off no strobe", strobes_now(), 0);
            cyc(16'h1000, 1'b0);
            chk("R7 off step holds", int'(step), 3);
        end
    endtask

    task automatic t_turn_on();
        cyc(16'h0000, 1'b1);
        chk("R8 no strobe on turn-on", strobes_now(), 0);
        cyc(16'h0000, 1'b1);
        chk("R8 step restarts", int'(step), 0);
        exp_step = 0;
        one_fall();
        chk("R8 runs from step 0", int'(step), 1);
    endtask

    initial begin
        t_reset();
        t_first_cycle();
        t_full_cycle();
        t_other_bits();
        t_off();
        t_turn_on();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule